// File: doc/BRIEF.md
# Keyed Watchdog Timer

A memory-mapped watchdog built around a 32-bit down-counter that advances only on cycles where the core tick enable is high. Software programs a reload value and turns the counter on. When the counter runs out, the block raises an interrupt and starts a new period. If software has not acknowledged that interrupt by the time the counter runs out again, the block raises a reset request. The request holds until the system reset. A full timeout from a reload value L therefore takes about 2·(L+1) ticks.

Every register except the lock register ignores writes until software writes a 32-bit key to the lock register. Writing any other value to the lock register locks the block again. The bus is a single-cycle register port. Writes take effect on the clock edge, and read data is a combinational function of the address.

The pending-interrupt state is held in a three-state machine. QUIET means no interrupt is pending. PENDING means the first expiry has happened and has not been acknowledged. TRIPPED means the reset request is asserted. The transitions are:
- ARM_IRQ (QUIET to PENDING) on an expiry.
- ACK (PENDING to QUIET) on a write to the clear register.
- REARM (PENDING to PENDING) on an expiry while the reset enable is off.
- FIRE (PENDING to TRIPPED) on an expiry while the reset enable is on.
- STICK (TRIPPED to TRIPPED) on every cycle until the system reset.

Top module: `keyed_watchdog`

Register offsets, with read data in bits 31:0:

| Offset | Register | Access | Contents |
|---|---|---|---|
| 0x000 | load | read/write | reload value |
| 0x004 | value | read-only | current counter value |
| 0x008 | control | read/write | bit 0 run, bit 1 reset enable |
| 0x00C | clear | write-only | any write acknowledges the interrupt |
| 0x010 | raw status | read-only | bit 0 pending interrupt |
| 0x014 | masked status | read-only | bit 0 pending interrupt AND run |
| 0xC00 | lock | read/write | bit 0 reads 1 while locked |

## Requirements
- R1: After reset the block is locked and the lock register at 0xC00 reads 1. The load register (0x000) and the counter value (0x004) read 0xFFFFFFFF. Control (0x008) reads 0. No interrupt is pending, and irq_o and rst_req_o are low.
- R2: While control bit 0 (run) is set and the block is not TRIPPED, each cycle with tick_en high and a nonzero counter decrements the counter by one. With tick_en low or run clear, the counter holds its value.
- R3: A write of 0x1ACCE551 to offset 0xC00 unlocks the block. A write of any other value to 0xC00 locks it. Bit 0 of 0xC00 reads 1 while locked and 0 while unlocked, and the other bits read 0.
- R4: While the block is locked, writes to every offset other than 0xC00 change nothing.
- R5: A write to the load register stores the value and loads the counter with it on the same edge. A control write with bit 0 set loads the counter from the load register, even when the counter is already running.
- R6: An expiry is a cycle in which the counter is running, tick_en is high and the counter is 0. On the first expiry the raw interrupt is set (QUIET to PENDING) and the counter reloads. A reload value L therefore gives one expiry every L+1 ticks.
- R7: An expiry in PENDING with control bit 1 (reset enable) set moves the block to TRIPPED. In TRIPPED, rst_req_o is high until rst_n, the counter stops at 0, and a clear write does not release it. An expiry in PENDING with reset enable clear reloads the counter and stays PENDING.
- R8: Bit 0 of raw status (0x010) shows the pending interrupt whatever the run bit is. Bit 0 of masked status (0x014) and irq_o are high exactly when an interrupt is pending and the run bit is set.
- R9: Any unlocked write to the clear register (0x00C) empties a pending interrupt and reloads the counter. A clear, load write or control reload on the same edge as an expiry takes priority, so no expiry happens on that edge.
- R10: Control reads back only bits 1:0, and bits 31:2 read 0. The clear register and unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter tick enable |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Masked watchdog interrupt |
| rst_req_o | output | 1 | Reset request, held once asserted |

## Verification
Two functions can fall on the same clock edge: the second expiry, which would assert the reset request, and a clear write. To provoke this, the bench runs the counter with the reset enable set until an interrupt is pending. It then reads the value register on every cycle and issues the clear exactly on the edge where the counter sits at zero with a tick present. The outcome is judged by the reset request staying low, the raw status reading 0 and the counter reading the reload value. A behavioural model run alongside the design must agree on every cycle.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_LOAD   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_VALUE  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'hC00;

    localparam int CTL_RUN_BIT = 0;
    localparam int CTL_RST_BIT = 1;

    typedef enum logic [1:0] {
        WD_QUIET   = 2'd0,
        WD_PENDING = 2'd1,
        WD_TRIPPED = 2'd2
    } wd_state_e;

endpackage

// File: rtl/kwd_lock.sv
`timescale 1ns/1ps
module kwd_lock #(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY    = 32'h1ACCE551
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked
);

    // Comes out of reset guarded; only the exact key opens it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked <= 1'b1;
        end else if (lock_wr) begin
            locked <= (wdata != KEY);
        end
    end

endmodule

// File: rtl/kwd_core.sv
`timescale 1ns/1ps
module kwd_core
    import kwd_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] LOAD_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run_en,
    input  logic              rst_en,
    input  logic              reload_req,
    input  logic [DATA_W-1:0] reload_val,
    input  logic [DATA_W-1:0] load_val,
    input  logic              clr_req,
    output logic [DATA_W-1:0] count,
    output logic              raw_irq,
    output logic              trip
);

    wd_state_e         state_q, state_d;
    logic [DATA_W-1:0] count_q;
    logic              active;
    logic              expire;

    assign active = run_en && (state_q != WD_TRIPPED);
    // A software reload on the same edge wins over the expiry.
    assign expire = active && tick && (count_q == '0) && !reload_req;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: ARM_IRQ, ACK, REARM, FIRE, STICK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_QUIET: begin
                if (expire) state_d = WD_PENDING;
            end
            WD_PENDING: begin
                if (clr_req)               state_d = WD_QUIET;
                else if (expire && rst_en) state_d = WD_TRIPPED;
            end
            WD_TRIPPED: state_d = WD_TRIPPED;
            default:    state_d = WD_QUIET;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        raw_irq = (state_q != WD_QUIET);
        trip    = (state_q == WD_TRIPPED);
    end

    // Down-counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= LOAD_INIT;
        end else if (reload_req) begin
            count_q <= reload_val;
        end else if (expire) begin
            if ((state_q == WD_PENDING) && rst_en) count_q <= '0;
            else                                   count_q <= load_val;
        end else if (active && tick) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/kwd_regfile.sv
`timescale 1ns/1ps
module kwd_regfile
    import kwd_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] LOAD_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] count,
    input  logic              raw_irq,
    input  logic              locked,
    output logic [DATA_W-1:0] load_q,
    output logic              run_en,
    output logic              rst_en,
    output logic              ld_wr,
    output logic              ctl_wr,
    output logic              clr_wr,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAD_CTL = DATA_W - 2;
    localparam int PAD_BIT = DATA_W - 1;

    assign ld_wr  = wr_ok && (addr == OFS_LOAD);
    assign ctl_wr = wr_ok && (addr == OFS_CTRL);
    assign clr_wr = wr_ok && (addr == OFS_CLEAR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= LOAD_INIT;
            run_en <= 1'b0;
            rst_en <= 1'b0;
        end else begin
            if (ld_wr) load_q <= wdata;
            if (ctl_wr) begin
                run_en <= wdata[CTL_RUN_BIT];
                rst_en <= wdata[CTL_RST_BIT];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_LOAD:   rdata = load_q;
            OFS_VALUE:  rdata = count;
            OFS_CTRL:   rdata = {{PAD_CTL{1'b0}}, rst_en, run_en};
            OFS_RAW:    rdata = {{PAD_BIT{1'b0}}, raw_irq};
            OFS_MASKED: rdata = {{PAD_BIT{1'b0}}, raw_irq & run_en};
            OFS_LOCK:   rdata = {{PAD_BIT{1'b0}}, locked};
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog #(
    parameter int                DATA_W     = 32,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551,
    parameter logic [DATA_W-1:0] LOAD_INIT  = '1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_en,
    input  logic [kwd_pkg::ADDR_W-1:0] bus_addr,
    input  logic                      bus_we,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic                      irq_o,
    output logic                      rst_req_o
);

    logic              locked_q;
    logic              lock_wr;
    logic              wr_ok;
    logic              ld_wr, ctl_wr, clr_wr;
    logic [DATA_W-1:0] load_q;
    logic              run_en, rst_en;
    logic [DATA_W-1:0] count_q;
    logic              raw_irq, trip;
    logic              reload_req;
    logic [DATA_W-1:0] reload_val;

    assign lock_wr = bus_we && (bus_addr == kwd_pkg::OFS_LOCK);
    assign wr_ok   = bus_we && !locked_q;

    kwd_lock #(.DATA_W(DATA_W), .KEY(UNLOCK_KEY)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock_wr(lock_wr),
        .wdata  (bus_wdata),
        .locked (locked_q)
    );

    kwd_regfile #(.DATA_W(DATA_W), .LOAD_INIT(LOAD_INIT)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ok  (wr_ok),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .count  (count_q),
        .raw_irq(raw_irq),
        .locked (locked_q),
        .load_q (load_q),
        .run_en (run_en),
        .rst_en (rst_en),
        .ld_wr  (ld_wr),
        .ctl_wr (ctl_wr),
        .clr_wr (clr_wr),
        .rdata  (bus_rdata)
    );

    // Reload sources: new load value, acknowledge, or a run-bit write.
    assign reload_req = ld_wr || clr_wr || (ctl_wr && bus_wdata[kwd_pkg::CTL_RUN_BIT]);
    assign reload_val = ld_wr ? bus_wdata : load_q;

    kwd_core #(.DATA_W(DATA_W), .LOAD_INIT(LOAD_INIT)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_en),
        .run_en    (run_en),
        .rst_en    (rst_en),
        .reload_req(reload_req),
        .reload_val(reload_val),
        .load_val  (load_q),
        .clr_req   (clr_wr),
        .count     (count_q),
        .raw_irq   (raw_irq),
        .trip      (trip)
    );

    assign irq_o     = raw_irq && run_en;
    assign rst_req_o = trip;

endmodule

// File: rtl/kwd_checker.sv
`timescale 1ns/1ps
module kwd_checker
    import kwd_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY    = 32'h1ACCE551
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rst_req_o,
    input logic              locked,
    input logic [DATA_W-1:0] load_q,
    input logic [DATA_W-1:0] count,
    input logic              raw_irq,
    input logic              run_en
);

    logic wr_ok;
    assign wr_ok = bus_we && !locked;

    assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !rst_req_o && tick_en && (count != '0) && !wr_ok)
        |=> (count == $past(count) - 1'b1));

    assert_key_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == OFS_LOCK) && (bus_wdata == KEY)) |=> !locked);

    assert_locked_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && bus_we && (bus_addr != OFS_LOCK)) |=> $stable(load_q));

    assert_irq_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_irq) |-> ($past(count) == '0));

    assert_trip_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> $past(raw_irq));

    assert_reset_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> rst_req_o);

    assert_clear_acks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && (bus_addr == OFS_CLEAR) && !rst_req_o) |=> !raw_irq);

endmodule

bind keyed_watchdog kwd_checker #(.DATA_W(DATA_W), .KEY(UNLOCK_KEY)) u_kwd_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .rst_req_o(rst_req_o),
    .locked   (locked_q),
    .load_q   (load_q),
    .count    (count_q),
    .raw_irq  (raw_irq),
    .run_en   (run_en)
);

// File: tb/test_keyed_watchdog.sv
`timescale 1ns/1ps
module test_keyed_watchdog;

    localparam logic [31:0] KEY = 32'h1ACCE551;
    localparam logic [11:0] A_LOAD = 12'h000, A_VAL = 12'h004, A_CTL = 12'h008,
                            A_CLR = 12'h00C, A_RAW = 12'h010, A_MSK = 12'h014,
                            A_LOCK = 12'hC00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, rst_req_o;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    keyed_watchdog i_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    // Behavioural reference: state 0 none pending, 1 pending, 2 reset fired
    logic [31:0] m_load = '1, m_count = '1;
    logic [1:0]  m_ctrl = '0;
    bit          m_locked = 1'b1;
    int          m_state = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_load = '1; m_count = '1; m_ctrl = '0; m_locked = 1'b1; m_state = 0;
        end else begin
            bit ok, ld, ctl, clr, rel, act, exp_now;
            logic [31:0] rv;
            ok  = bus_we && !m_locked;
            ld  = ok && bus_addr == A_LOAD;
            ctl = ok && bus_addr == A_CTL;
            clr = ok && bus_addr == A_CLR;
            rel = ld || clr || (ctl && bus_wdata[0]);
            rv  = ld ? bus_wdata : m_load;
            act = m_ctrl[0] && m_state != 2;
            exp_now = act && tick_en && m_count == 0 && !rel;
            if (rel) m_count = rv;
            else if (exp_now) m_count = (m_state == 1 && m_ctrl[1]) ? 32'd0 : m_load;
            else if (act && tick_en) m_count = m_count - 1;
            if (m_state != 2) begin
                if (clr) m_state = 0;
                else if (exp_now) m_state = (m_state == 0) ? 1 : (m_ctrl[1] ? 2 : 1);
            end
            if (ld) m_load = bus_wdata;
            if (ctl) m_ctrl = bus_wdata[1:0];
            if (bus_we && bus_addr == A_LOCK) m_locked = (bus_wdata != KEY);
        end
    end

    function automatic logic [31:0] model_rd(input logic [11:0] a);
        case (a)
            A_LOAD: return m_load;
            A_VAL:  return m_count;
            A_CTL:  return {30'd0, m_ctrl};
            A_RAW:  return {31'd0, m_state != 0};
            A_MSK:  return {31'd0, (m_state != 0) && m_ctrl[0]};
            A_LOCK: return {31'd0, m_locked};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 rdata vs model", bus_rdata, model_rd(bus_addr));
            chk("R8 irq_o vs model", {31'd0, irq_o}, {31'd0, (m_state != 0) && m_ctrl[0]});
            chk("R7 rst_req_o vs model", {31'd0, rst_req_o}, {31'd0, m_state == 2});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_checks++; n_errors++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
        step();
    endtask

    task automatic expect_rd(input string tag, input logic [11:0] a, input logic [31:0] e);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, e);
    endtask

    initial begin
        bit hit;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        expect_rd("R1 lock reads 1", A_LOCK, 32'd1);
        expect_rd("R1 load reset", A_LOAD, 32'hFFFF_FFFF);
        expect_rd("R1 value reset", A_VAL, 32'hFFFF_FFFF);
        expect_rd("R1 control reset", A_CTL, 32'd0);
        chk("R1 irq/rst low", {30'd0, irq_o, rst_req_o}, 32'd0);

        wr(A_LOAD, 32'd5);
        expect_rd("R4 locked load write ignored", A_LOAD, 32'hFFFF_FFFF);
        wr(A_CTL, 32'd3);
        expect_rd("R4 locked control write ignored", A_CTL, 32'd0);

        wr(A_LOCK, KEY);
        expect_rd("R3 key unlocks", A_LOCK, 32'd0);

        wr(A_LOAD, 32'd7);
        expect_rd("R5 load write reloads value", A_VAL, 32'd7);

        wr(A_CTL, 32'hFFFF_FFFC);
        expect_rd("R10 reserved control bits", A_CTL, 32'd0);
        wr(A_CTL, 32'hFFFF_FFFD);
        expect_rd("R10 control keeps bits 1:0", A_CTL, 32'd1);
        expect_rd("R10 clear reads zero", A_CLR, 32'd0);
        expect_rd("R5 run write reloads", A_VAL, 32'd7);

        tick_en = 1'b1; repeat (3) step(); tick_en = 1'b0;
        expect_rd("R2 three ticks decrement", A_VAL, 32'd4);
        expect_rd("R2 no tick holds", A_VAL, 32'd4);

        tick_en = 1'b1; repeat (5) step(); tick_en = 1'b0;
        expect_rd("R6 first expiry raw", A_RAW, 32'd1);
        expect_rd("R6 expiry reloads", A_VAL, 32'd7);
        expect_rd("R8 masked while running", A_MSK, 32'd1);

        wr(A_CTL, 32'd0);
        expect_rd("R8 raw ignores run bit", A_RAW, 32'd1);
        expect_rd("R8 masked off when stopped", A_MSK, 32'd0);
        chk("R8 irq_o low when stopped", {31'd0, irq_o}, 32'd0);

        wr(A_CTL, 32'd1);
        tick_en = 1'b1; repeat (8) step(); tick_en = 1'b0;
        chk("R7 no reset without enable", {31'd0, rst_req_o}, 32'd0);
        expect_rd("R7 stays pending and reloads", A_VAL, 32'd7);

        wr(A_CLR, 32'd0);
        expect_rd("R9 clear empties raw", A_RAW, 32'd0);

        // Same-edge clear and second expiry
        wr(A_CTL, 32'd3);
        tick_en = 1'b1; repeat (8) step();
        hit = 1'b0;
        bus_addr = A_VAL;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bus_rdata == 32'd0) begin
                #1; bus_we = 1'b1; bus_addr = A_CLR; bus_wdata = 32'd0;
                step();
                bus_we = 1'b0; hit = 1'b1;
                break;
            end
        end
        tick_en = 1'b0;
        chk("R9 clear met zero count", {31'd0, hit}, 32'd1);
        chk("R9 clear beats expiry: no reset", {31'd0, rst_req_o}, 32'd0);
        expect_rd("R9 clear beats expiry: raw", A_RAW, 32'd0);
        expect_rd("R9 clear beats expiry: value", A_VAL, 32'd7);

        tick_en = 1'b1; repeat (16) step(); tick_en = 1'b0;
        chk("R7 second expiry fires", {31'd0, rst_req_o}, 32'd1);
        expect_rd("R7 counter stops at zero", A_VAL, 32'd0);
        wr(A_CLR, 32'd0);
        tick_en = 1'b1; repeat (3) step(); tick_en = 1'b0;
        chk("R7 reset held after clear", {31'd0, rst_req_o}, 32'd1);

        rst_n = 1'b0; repeat (2) step(); rst_n = 1'b1; step();
        chk("R1 reset releases request", {31'd0, rst_req_o}, 32'd0);
        expect_rd("R1 relocked after reset", A_LOCK, 32'd1);

        wr(A_LOCK, KEY);
        wr(A_LOCK, 32'h1ACC_E550);
        expect_rd("R3 wrong value locks", A_LOCK, 32'd1);
        wr(A_LOAD, 32'd9);
        expect_rd("R4 relocked load ignored", A_LOAD, 32'hFFFF_FFFF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule